// File: doc/BRIEF.md
# Fast System Call State Unit

This unit performs the architectural state changes for a fast privilege-crossing pair of operations: a quick entry from user level into the most privileged level, and a quick return from that level to user level. Its configuration is three registers: a kernel code selector, a kernel entry pointer and a kernel stack pointer. Software loads them through a small write port. An entry strobe copies that configuration into the live code selector, instruction pointer and stack pointer. The stack selector is formed as the code selector plus a fixed offset. The privilege level is set to 0 and the virtual-mode flag is cleared. A return strobe forms the user code and stack selectors from the same configured selector using two further fixed offsets. The user instruction and stack pointers are taken from two input ports, and the privilege level becomes 3. Neither operation pushes anything onto a stack.

The unit also judges privileged operation classes against the current level. An operation in a privileged class that is issued while the level is not 0 raises a fault pulse. Illegal transfer requests raise a separate fault pulse and leave all state untouched. Instruction decode, memory and the general register file lie outside the unit.

Top module: `fsc_state_unit`

## Requirements
- R1: After reset, code_sel, stack_sel, instr_ptr and stack_ptr are 0, priv_level is 3 and virt_flag is 1. xfer_done, xfer_fault and priv_fault are 0.
- R2: A configuration write with cfg_wr_addr 0 stores cfg_wr_data[15:0] as the kernel code selector. Address 1 stores the kernel entry pointer and address 2 the kernel stack pointer. A write to address 3 changes no register.
- R3: A valid entry loads code_sel from the kernel code selector, stack_sel with that selector plus 8 (modulo 2^16), instr_ptr from the entry pointer and stack_ptr from the kernel stack pointer.
- R4: A valid entry sets priv_level to 0 and clears virt_flag.
- R5: A valid return sets code_sel to the kernel code selector plus 16 and stack_sel to it plus 24, both modulo 2^16. It sets instr_ptr to ret_ip_in, stack_ptr to ret_sp_in and priv_level to 3, and leaves virt_flag unchanged.
- R6: All updates of a valid transfer appear together at the clock edge that samples the strobe. xfer_done is high for exactly the one following cycle.
- R7: A return strobe while priv_level is not 0 pulses xfer_fault for one cycle and changes no state.
- R8: An entry strobe while the kernel code selector is null (bits 15:2 all zero) pulses xfer_fault for one cycle and changes no state.
- R9: Entry and return strobes in the same cycle pulse xfer_fault for one cycle and change no state.
- R10: An entry in the same cycle as a configuration write uses the register values from before that write.
- R11: op_valid with op_class 1 to 8 (table load, task register load, control register move, debug register move, cache invalidate, translation buffer invalidate, halt, configuration register access) pulses priv_fault in the next cycle when priv_level is not 0. Classes 0 and 9 to 15 never do, and no class does at level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write enable |
| cfg_wr_addr | input | 2 | Configuration register select |
| cfg_wr_data | input | 32 | Configuration write data |
| enter_req | input | 1 | Fast entry strobe |
| exit_req | input | 1 | Fast return strobe |
| ret_ip_in | input | 32 | User instruction pointer for a return |
| ret_sp_in | input | 32 | User stack pointer for a return |
| op_valid | input | 1 | An operation of class op_class is issued |
| op_class | input | 4 | Operation class code |
| code_sel | output | 16 | Live code selector |
| stack_sel | output | 16 | Live stack selector |
| instr_ptr | output | 32 | Live instruction pointer |
| stack_ptr | output | 32 | Live stack pointer |
| priv_level | output | 2 | Current privilege level |
| virt_flag | output | 1 | Virtual-mode flag |
| xfer_done | output | 1 | One-cycle pulse after a valid transfer |
| xfer_fault | output | 1 | One-cycle pulse after a rejected transfer |
| priv_fault | output | 1 | One-cycle pulse after a privileged operation at a non-zero level |

## Verification
The configuration registers cannot be read at the ports, so two cases are hard to observe: an ignored write to address 3, and an entry that coincides with a configuration write. Both become visible only through a later entry. The bench therefore programs known values, issues the write under test, and then performs an entry whose copied outputs show which register contents were used. The offset arithmetic near the top of the selector range is reached by sweeping selectors up to 16'hFFF8, where the added offsets wrap.

// File: rtl/fsc_pkg.sv
// Package: shared widths, transfer kinds and the live state record of the
// fast system call state unit. Assumes a 16-bit selector, 32-bit pointers.
package fsc_pkg;

    parameter int SEL_W  = 16;
    parameter int PTR_W  = 32;
    parameter int PRIV_W = 2;
    parameter int CLS_W  = 4;

    localparam int NUM_CLS = 1 << CLS_W;

    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_ENTER = 2'd1,
        XF_EXIT  = 2'd2,
        XF_FAULT = 2'd3
    } xfer_kind_e;

    typedef struct packed {
        logic [SEL_W-1:0]  code_sel;
        logic [SEL_W-1:0]  stack_sel;
        logic [PTR_W-1:0]  instr_ptr;
        logic [PTR_W-1:0]  stack_ptr;
        logic [PRIV_W-1:0] priv;
        logic              vm;
    } arch_state_t;

endpackage

// File: rtl/fsc_cfg_regs.sv
// Module: fsc_cfg_regs
// Holds the kernel code selector, kernel entry pointer and kernel stack
// pointer. One write per cycle through a 2-bit address; the unused address
// is ignored. Outputs show the registered (pre-write) values.
module fsc_cfg_regs
    import fsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [PTR_W-1:0] wr_data,
    output logic [SEL_W-1:0] kern_sel,
    output logic [PTR_W-1:0] kern_entry,
    output logic [PTR_W-1:0] kern_stack
);

    localparam logic [1:0] ADDR_SEL   = 2'd0;
    localparam logic [1:0] ADDR_ENTRY = 2'd1;
    localparam logic [1:0] ADDR_STACK = 2'd2;

    logic [SEL_W-1:0] sel_q;
    logic [PTR_W-1:0] entry_q;
    logic [PTR_W-1:0] stack_q;

    // Purpose: reset or update the addressed configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            entry_q <= '0;
            stack_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_SEL:   sel_q   <= wr_data[SEL_W-1:0];
                ADDR_ENTRY: entry_q <= wr_data;
                ADDR_STACK: stack_q <= wr_data;
                default:    ;
            endcase
        end
    end

    assign kern_sel   = sel_q;
    assign kern_entry = entry_q;
    assign kern_stack = stack_q;

endmodule

// File: rtl/fsc_xfer_ctrl.sv
// Module: fsc_xfer_ctrl
// Combinational transfer decision: classifies the strobes as idle, entry,
// return or fault and forms the next live state. Assumes the caller only
// commits the next state for entry and return kinds.
module fsc_xfer_ctrl
    import fsc_pkg::*;
#(
    parameter int unsigned ENTER_SS_OFS = 8,
    parameter int unsigned EXIT_CS_OFS  = 16,
    parameter int unsigned EXIT_SS_OFS  = 24,
    parameter int unsigned USER_PRIV    = 3
) (
    input  logic             enter_req,
    input  logic             exit_req,
    input  arch_state_t      cur,
    input  logic [SEL_W-1:0] kern_sel,
    input  logic [PTR_W-1:0] kern_entry,
    input  logic [PTR_W-1:0] kern_stack,
    input  logic [PTR_W-1:0] ret_ip,
    input  logic [PTR_W-1:0] ret_sp,
    output xfer_kind_e       kind,
    output arch_state_t      nxt
);

    localparam logic [SEL_W-1:0]  ENT_SS = SEL_W'(ENTER_SS_OFS);
    localparam logic [SEL_W-1:0]  EXT_CS = SEL_W'(EXIT_CS_OFS);
    localparam logic [SEL_W-1:0]  EXT_SS = SEL_W'(EXIT_SS_OFS);
    localparam logic [PRIV_W-1:0] P_USER = PRIV_W'(USER_PRIV);
    localparam logic [PRIV_W-1:0] P_KERN = '0;

    logic sel_null;
    logic at_kernel;

    // Purpose: a selector whose index field is zero is null.
    assign sel_null  = (kern_sel[SEL_W-1:2] == '0);
    assign at_kernel = (cur.priv == P_KERN);

    // Purpose: classify the request, with conflicting strobes rejected.
    always_comb begin
        kind = XF_IDLE;
        if (enter_req && exit_req) begin
            kind = XF_FAULT;
        end else if (enter_req) begin
            kind = sel_null ? XF_FAULT : XF_ENTER;
        end else if (exit_req) begin
            kind = at_kernel ? XF_EXIT : XF_FAULT;
        end
    end

    // Purpose: build the state that a committed transfer would load.
    always_comb begin
        nxt = cur;
        case (kind)
            XF_ENTER: begin
                nxt.code_sel  = kern_sel;
                nxt.stack_sel = kern_sel + ENT_SS;
                nxt.instr_ptr = kern_entry;
                nxt.stack_ptr = kern_stack;
                nxt.priv      = P_KERN;
                nxt.vm        = 1'b0;
            end
            XF_EXIT: begin
                nxt.code_sel  = kern_sel + EXT_CS;
                nxt.stack_sel = kern_sel + EXT_SS;
                nxt.instr_ptr = ret_ip;
                nxt.stack_ptr = ret_sp;
                nxt.priv      = P_USER;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/fsc_priv_gate.sv
// Module: fsc_priv_gate
// Flags an issued operation whose class is marked privileged in the class
// mask while the current level is not 0. One decoder slice per class.
module fsc_priv_gate
    import fsc_pkg::*;
#(
    parameter logic [NUM_CLS-1:0] PRIV_CLASS_MASK = 16'h01FE
) (
    input  logic              op_valid,
    input  logic [CLS_W-1:0]  op_class,
    input  logic [PRIV_W-1:0] cur_priv,
    output logic              violation
);

    logic [NUM_CLS-1:0] hit;

    // Purpose: one match term per class, kept only for privileged classes.
    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        if (PRIV_CLASS_MASK[c]) begin : g_priv
            assign hit[c] = op_valid && (op_class == CLS_W'(c));
        end else begin : g_free
            assign hit[c] = 1'b0;
        end
    end

    // Purpose: a privileged match outside level 0 is a violation.
    assign violation = (|hit) && (cur_priv != '0);

endmodule

// File: rtl/fsc_state_unit.sv
// Module: fsc_state_unit (top)
// Holds the live code/stack selectors, pointers, privilege level and
// virtual-mode flag, and commits fast entry and return transfers on the
// edge that samples the strobe. Result pulses are registered one cycle.
// Assumes strobes are single-cycle and that reset is synchronous, active low.
module fsc_state_unit
    import fsc_pkg::*;
#(
    parameter int unsigned ENTER_SS_OFS = 8,
    parameter int unsigned EXIT_CS_OFS  = 16,
    parameter int unsigned EXIT_SS_OFS  = 24,
    parameter int unsigned USER_PRIV    = 3,
    parameter logic        RST_VM       = 1'b1,
    parameter logic [NUM_CLS-1:0] PRIV_CLASS_MASK = 16'h01FE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_wr_addr,
    input  logic [PTR_W-1:0]  cfg_wr_data,
    input  logic              enter_req,
    input  logic              exit_req,
    input  logic [PTR_W-1:0]  ret_ip_in,
    input  logic [PTR_W-1:0]  ret_sp_in,
    input  logic              op_valid,
    input  logic [CLS_W-1:0]  op_class,
    output logic [SEL_W-1:0]  code_sel,
    output logic [SEL_W-1:0]  stack_sel,
    output logic [PTR_W-1:0]  instr_ptr,
    output logic [PTR_W-1:0]  stack_ptr,
    output logic [PRIV_W-1:0] priv_level,
    output logic              virt_flag,
    output logic              xfer_done,
    output logic              xfer_fault,
    output logic              priv_fault
);

    localparam logic [PRIV_W-1:0] P_RESET = PRIV_W'(USER_PRIV);

    logic [SEL_W-1:0] cfg_sel;
    logic [PTR_W-1:0] cfg_entry;
    logic [PTR_W-1:0] cfg_stack;

    arch_state_t state_q;
    arch_state_t state_nxt;
    xfer_kind_e  kind;
    logic        viol;
    logic        commit;
    logic        done_q;
    logic        fault_q;
    logic        pfault_q;

    fsc_cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr_en),
        .wr_addr    (cfg_wr_addr),
        .wr_data    (cfg_wr_data),
        .kern_sel   (cfg_sel),
        .kern_entry (cfg_entry),
        .kern_stack (cfg_stack)
    );

    fsc_xfer_ctrl #(
        .ENTER_SS_OFS (ENTER_SS_OFS),
        .EXIT_CS_OFS  (EXIT_CS_OFS),
        .EXIT_SS_OFS  (EXIT_SS_OFS),
        .USER_PRIV    (USER_PRIV)
    ) u_xfer (
        .enter_req  (enter_req),
        .exit_req   (exit_req),
        .cur        (state_q),
        .kern_sel   (cfg_sel),
        .kern_entry (cfg_entry),
        .kern_stack (cfg_stack),
        .ret_ip     (ret_ip_in),
        .ret_sp     (ret_sp_in),
        .kind       (kind),
        .nxt        (state_nxt)
    );

    fsc_priv_gate #(
        .PRIV_CLASS_MASK (PRIV_CLASS_MASK)
    ) u_priv (
        .op_valid  (op_valid),
        .op_class  (op_class),
        .cur_priv  (state_q.priv),
        .violation (viol)
    );

    // Purpose: only entry and return kinds may alter the live state.
    assign commit = (kind == XF_ENTER) || (kind == XF_EXIT);

    // Purpose: hold the live state, loading all fields together on a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.code_sel  <= '0;
            state_q.stack_sel <= '0;
            state_q.instr_ptr <= '0;
            state_q.stack_ptr <= '0;
            state_q.priv      <= P_RESET;
            state_q.vm        <= RST_VM;
        end else if (commit) begin
            state_q <= state_nxt;
        end
    end

    // Purpose: register the one-cycle result and fault pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            fault_q  <= 1'b0;
            pfault_q <= 1'b0;
        end else begin
            done_q   <= commit;
            fault_q  <= (kind == XF_FAULT);
            pfault_q <= viol;
        end
    end

    assign code_sel   = state_q.code_sel;
    assign stack_sel  = state_q.stack_sel;
    assign instr_ptr  = state_q.instr_ptr;
    assign stack_ptr  = state_q.stack_ptr;
    assign priv_level = state_q.priv;
    assign virt_flag  = state_q.vm;
    assign xfer_done  = done_q;
    assign xfer_fault = fault_q;
    assign priv_fault = pfault_q;

endmodule

// File: rtl/fsc_state_unit_chk.sv
// Module: fsc_state_unit_chk
// Temporal checks on the state unit, bound to every instance of the top.
// Assumes the default selector offsets of 8, 16 and 24.
module fsc_state_unit_chk
    import fsc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              enter_req,
    input logic              exit_req,
    input logic [PTR_W-1:0]  ret_ip_in,
    input logic [PTR_W-1:0]  ret_sp_in,
    input logic [SEL_W-1:0]  cfg_sel,
    input logic [PTR_W-1:0]  cfg_entry,
    input logic [PTR_W-1:0]  cfg_stack,
    input logic [SEL_W-1:0]  code_sel,
    input logic [SEL_W-1:0]  stack_sel,
    input logic [PTR_W-1:0]  instr_ptr,
    input logic [PTR_W-1:0]  stack_ptr,
    input logic [PRIV_W-1:0] priv_level,
    input logic              virt_flag,
    input logic              xfer_done,
    input logic              xfer_fault,
    input logic              priv_fault
);

    localparam logic [SEL_W-1:0] O8  = SEL_W'(8);
    localparam logic [SEL_W-1:0] O16 = SEL_W'(16);
    localparam logic [SEL_W-1:0] O24 = SEL_W'(24);

    logic ok_enter;
    logic ok_exit;
    assign ok_enter = enter_req && !exit_req && (cfg_sel[SEL_W-1:2] != '0);
    assign ok_exit  = exit_req && !enter_req && (priv_level == '0);

    assert_entry_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ok_enter |=> (code_sel == $past(cfg_sel)) &&
                     (stack_sel == SEL_W'($past(cfg_sel) + O8)) &&
                     (instr_ptr == $past(cfg_entry)) &&
                     (stack_ptr == $past(cfg_stack)));

    assert_entry_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ok_enter |=> (priv_level == '0) && !virt_flag);

    assert_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ok_exit |=> (code_sel == SEL_W'($past(cfg_sel) + O16)) &&
                    (stack_sel == SEL_W'($past(cfg_sel) + O24)) &&
                    (instr_ptr == $past(ret_ip_in)) &&
                    (stack_ptr == $past(ret_sp_in)) &&
                    (priv_level == PRIV_W'(3)) &&
                    (virt_flag == $past(virt_flag)));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_enter || ok_exit) |=> xfer_done);

    assert_result_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xfer_done, xfer_fault}));

    assert_exit_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_req && (priv_level != '0)) |=> xfer_fault);

    assert_fault_keeps_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_fault |-> $stable(code_sel) && $stable(stack_sel) &&
                       $stable(instr_ptr) && $stable(stack_ptr) &&
                       $stable(priv_level) && $stable(virt_flag));

    assert_conflict_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_req && exit_req) |=> xfer_fault && !xfer_done);

    assert_priv_level0_R11: assert property (@(posedge clk) disable iff (!rst_n)
        priv_fault |-> ($past(priv_level) != '0));

endmodule

bind fsc_state_unit fsc_state_unit_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .enter_req  (enter_req),
    .exit_req   (exit_req),
    .ret_ip_in  (ret_ip_in),
    .ret_sp_in  (ret_sp_in),
    .cfg_sel    (cfg_sel),
    .cfg_entry  (cfg_entry),
    .cfg_stack  (cfg_stack),
    .code_sel   (code_sel),
    .stack_sel  (stack_sel),
    .instr_ptr  (instr_ptr),
    .stack_ptr  (stack_ptr),
    .priv_level (priv_level),
    .virt_flag  (virt_flag),
    .xfer_done  (xfer_done),
    .xfer_fault (xfer_fault),
    .priv_fault (priv_fault)
);

// File: tb/fsc_state_unit_tb_top.sv
// Bench: drives inputs on falling edges and samples on the next falling
// edge, with all expected values computed from the requirements.
module fsc_state_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_wr_addr = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        enter_req = 1'b0;
    logic        exit_req = 1'b0;
    logic [31:0] ret_ip_in = '0;
    logic [31:0] ret_sp_in = '0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_class = '0;
    logic [15:0] code_sel;
    logic [15:0] stack_sel;
    logic [31:0] instr_ptr;
    logic [31:0] stack_ptr;
    logic [1:0]  priv_level;
    logic        virt_flag;
    logic        xfer_done;
    logic        xfer_fault;
    logic        priv_fault;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    fsc_state_unit dut_i (
        .clk (clk), .rst_n (rst_n),
        .cfg_wr_en (cfg_wr_en), .cfg_wr_addr (cfg_wr_addr), .cfg_wr_data (cfg_wr_data),
        .enter_req (enter_req), .exit_req (exit_req),
        .ret_ip_in (ret_ip_in), .ret_sp_in (ret_sp_in),
        .op_valid (op_valid), .op_class (op_class),
        .code_sel (code_sel), .stack_sel (stack_sel),
        .instr_ptr (instr_ptr), .stack_ptr (stack_ptr),
        .priv_level (priv_level), .virt_flag (virt_flag),
        .xfer_done (xfer_done), .xfer_fault (xfer_fault), .priv_fault (priv_fault)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_state(input string req, input logic [15:0] cs,
                             input logic [15:0] ss, input logic [31:0] ip,
                             input logic [31:0] sp, input logic [1:0] pl,
                             input logic vm);
        chk(req, "code_sel", 64'(code_sel), 64'(cs));
        chk(req, "stack_sel", 64'(stack_sel), 64'(ss));
        chk(req, "instr_ptr", 64'(instr_ptr), 64'(ip));
        chk(req, "stack_ptr", 64'(stack_ptr), 64'(sp));
        chk(req, "priv_level", 64'(priv_level), 64'(pl));
        chk(req, "virt_flag", 64'(virt_flag), 64'(vm));
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    // One-cycle strobe; returns at the falling edge after the sampling edge.
    task automatic strobe(input logic en, input logic ex);
        enter_req = en; exit_req = ex;
        @(negedge clk);
        enter_req = 1'b0; exit_req = 1'b0;
    endtask

    task automatic program_cfg(input logic [15:0] s, input logic [31:0] e,
                               input logic [31:0] k);
        cfg_write(2'd0, {16'hA5A5, s});
        cfg_write(2'd1, e);
        cfg_write(2'd2, k);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] s;
        logic [31:0] e, k, rip, rsp;
        logic        exp_pf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk_state("R1", 16'h0, 16'h0, 32'h0, 32'h0, 2'd3, 1'b1);
        chk("R1", "pulses", 64'({xfer_done, xfer_fault, priv_fault}), 64'h0);

        // R7: return at level 3 rejected
        ret_ip_in = 32'h1111_0000; ret_sp_in = 32'h2222_0000;
        strobe(1'b0, 1'b1);
        chk("R7", "xfer_fault", 64'(xfer_fault), 64'h1);
        chk("R7", "xfer_done", 64'(xfer_done), 64'h0);
        chk_state("R7", 16'h0, 16'h0, 32'h0, 32'h0, 2'd3, 1'b1);
        @(negedge clk);
        chk("R7", "fault one cycle", 64'(xfer_fault), 64'h0);

        // R8: null selectors 0 and 3 rejected
        strobe(1'b1, 1'b0);
        chk("R8", "xfer_fault sel0", 64'(xfer_fault), 64'h1);
        chk_state("R8", 16'h0, 16'h0, 32'h0, 32'h0, 2'd3, 1'b1);
        program_cfg(16'h0003, 32'hDEAD_0001, 32'hBEEF_0001);
        strobe(1'b1, 1'b0);
        chk("R8", "xfer_fault sel3", 64'(xfer_fault), 64'h1);
        chk_state("R8", 16'h0, 16'h0, 32'h0, 32'h0, 2'd3, 1'b1);

        // R2: address 3 write ignored, seen through a later entry
        program_cfg(16'h0010, 32'h0000_4000, 32'h0000_8000);
        cfg_write(2'd3, 32'hFFFF_FFFF);
        strobe(1'b1, 1'b0);
        chk_state("R2", 16'h0010, 16'h0018, 32'h0000_4000, 32'h0000_8000, 2'd0, 1'b0);

        // R3 R4 R5 R6: sweep selectors including the wrapping top values
        for (int i = 0; i < 10; i++) begin
            s   = (i == 8) ? 16'hFFF8 : (i == 9) ? 16'hFFE8 : 16'(16'h0008 + i * 16'h1234);
            e   = 32'h0040_0000 + 32'(i) * 32'h0001_0101;
            k   = 32'h8000_0000 - 32'(i) * 32'h0000_0100;
            rip = 32'h0804_8000 + 32'(i) * 32'h10;
            rsp = 32'hBFFF_F000 - 32'(i) * 32'h40;
            program_cfg(s, e, k);
            strobe(1'b1, 1'b0);
            chk_state("R3", s, 16'(s + 16'd8), e, k, 2'd0, 1'b0);
            chk("R6", "done after entry", 64'(xfer_done), 64'h1);
            chk("R4", "level after entry", 64'(priv_level), 64'h0);
            @(negedge clk);
            chk("R6", "done one cycle", 64'(xfer_done), 64'h0);
            ret_ip_in = rip; ret_sp_in = rsp;
            strobe(1'b0, 1'b1);
            chk_state("R5", 16'(s + 16'd16), 16'(s + 16'd24), rip, rsp, 2'd3, 1'b0);
            chk("R6", "done after return", 64'(xfer_done), 64'h1);
        end

        // R9: simultaneous strobes, at level 3 then level 0
        strobe(1'b1, 1'b1);
        chk("R9", "xfer_fault lvl3", 64'(xfer_fault), 64'h1);
        chk_state("R9", 16'hFFF8, 16'h0000, rip, rsp, 2'd3, 1'b0);
        strobe(1'b1, 1'b0);
        strobe(1'b1, 1'b1);
        chk("R9", "xfer_fault lvl0", 64'(xfer_fault), 64'h1);
        chk("R9", "no done", 64'(xfer_done), 64'h0);
        chk_state("R9", 16'hFFE8, 16'hFFF0, e, k, 2'd0, 1'b0);

        // R10: entry in the same cycle as a write uses the old values
        program_cfg(16'h0100, 32'h0000_1000, 32'h0000_2000);
        cfg_wr_en = 1'b1; cfg_wr_addr = 2'd0; cfg_wr_data = 32'h0000_0200;
        strobe(1'b1, 1'b0);
        cfg_wr_en = 1'b0;
        chk_state("R10", 16'h0100, 16'h0108, 32'h0000_1000, 32'h0000_2000, 2'd0, 1'b0);
        strobe(1'b1, 1'b0);
        chk("R10", "new sel later", 64'(code_sel), 64'h0200);

        // R11: class sweep at level 0 (no faults), then at level 3
        for (int lvl = 0; lvl < 2; lvl++) begin
            if (lvl == 1) strobe(1'b0, 1'b1);
            for (int c = 0; c < 16; c++) begin
                op_valid = 1'b1; op_class = 4'(c);
                @(negedge clk);
                op_valid = 1'b0;
                exp_pf = (lvl == 1) && (c >= 1) && (c <= 8);
                chk("R11", $sformatf("priv_fault lvl%0d class%0d", lvl, c),
                    64'(priv_fault), 64'(exp_pf));
            end
        end
        @(negedge clk);
        chk("R11", "idle no fault", 64'(priv_fault), 64'h0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule